// File: doc/BRIEF.md
# Vectored Interrupt Priority and In-Service Tracker

This block keeps the state of 256 interrupt vectors for one processor core: a request set (IRR) of vectors that have been raised and not yet taken, and an in-service set (ISR) of vectors the core has taken and not yet finished. From a task priority value (TPR) written by software and the highest vector in service, it forms a processor priority (PPR). It then offers the core the highest requested vector whose priority class beats the PPR.

Interrupt sources raise vectors through a one-vector-per-cycle set port. The core takes the offered vector with a one-cycle accept pulse, and signals completion with an end-of-interrupt (EOI) pulse. The IRR and ISR can be read one 32-bit word at a time through a word select. All state is registered. The offer and the PPR are combinational from that state, so every update is visible in the cycle after the clock edge that caused it.

Top module: `vec_prio_tracker`

## Requirements
- R1: After reset the IRR, ISR and TPR are all zero, `ppr_o` is 0 and `pend_valid_o` is 0.
- R2: The priority class of an 8-bit value is its bits [7:4]. PPR equals TPR when the TPR class is at least the class of the highest in-service vector. Otherwise PPR is that vector with bits [3:0] cleared.
- R3: With no vector in service, the highest in-service vector counts as 0, so `ppr_o` equals TPR.
- R4: Only requests for vectors 32 to 255 are considered. The highest one is offered (`pend_valid_o`=1, `pend_vec_o`=vector) only if its class is strictly greater than the PPR class; otherwise nothing is offered. Vectors 0 to 31 can be requested and read back, but are never offered.
- R5: `ack_i` high while `pend_valid_o` is 1 takes the offered vector: its IRR bit clears, its ISR bit sets and PPR follows. `ack_i` with nothing offered changes nothing.
- R6: `eoi_i` clears the highest set ISR bit among vectors 32 to 255 and PPR follows. With nothing in service it changes nothing.
- R7: `tpr_we_i` loads TPR from `tpr_wdata_i[7:0]`; the upper 24 bits are dropped.
- R8: Requesting a vector whose IRR bit is already set leaves all state unchanged.
- R9: When a request and an accept name the same vector in one cycle, the vector is both in service and still requested afterwards.
- R10: `irr_word_o` and `isr_word_o` show word `rd_sel_i`. Bit j of word i is vector 32*i+j.
- R11: Each set, accept, EOI or TPR write takes effect at one rising edge and is visible on the outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | Raise a request for `set_vec_i` |
| set_vec_i | input | 8 | Vector to request |
| ack_i | input | 1 | Core takes the offered vector |
| eoi_i | input | 1 | End of interrupt for the highest in-service vector |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 32 | Task priority write data (low byte used) |
| rd_sel_i | input | 3 | Word select for the IRR/ISR read outputs |
| pend_valid_o | output | 1 | A vector is offered to the core |
| pend_vec_o | output | 8 | Offered vector |
| ppr_o | output | 8 | Processor priority |
| irr_word_o | output | 32 | Selected IRR word |
| isr_word_o | output | 32 | Selected ISR word |

## Verification
Directed sequences check the priority gate at its edges. A request in the same class as the PPR must stay held while one a class higher is offered. Nested accepts must raise PPR to each new class and EOIs must unwind it in reverse order. TPR values above, equal to and below the in-service class tell the two arms of the PPR choice apart. A request in the reserved range shows the scan floor. A long stretch of random sets, accepts, EOIs and TPR writes, with the read select sweeping every word, is compared cycle by cycle against a behavioural model. This catches ordering slips between simultaneous events and wrong bit-to-word placement.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  localparam int CLS_W = 4;  // priority class = top CLS_W bits of a vector
endpackage

// File: rtl/vpt_msb_find.sv
module vpt_msb_find #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/vpt_ppr_calc.sv
module vpt_ppr_calc
  import vpt_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic [VEC_W-1:0] isr_top_i,
  output logic [VEC_W-1:0] ppr_o
);
  logic [CLS_W-1:0] tpr_cls, isr_cls;
  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign isr_cls = isr_top_i[VEC_W-1 -: CLS_W];
  assign ppr_o = (tpr_cls >= isr_cls) ? tpr_i
                                      : {isr_cls, {(VEC_W-CLS_W){1'b0}}};
endmodule

// File: rtl/vec_prio_tracker.sv
module vec_prio_tracker
  import vpt_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int RSVD    = 32,
  parameter int WORD_W  = 32,
  parameter int TPR_W   = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           set_valid_i,
  input  logic [$clog2(NUM_VEC)-1:0]     set_vec_i,
  input  logic                           ack_i,
  input  logic                           eoi_i,
  input  logic                           tpr_we_i,
  input  logic [TPR_W-1:0]               tpr_wdata_i,
  input  logic [$clog2(NUM_VEC/WORD_W)-1:0] rd_sel_i,
  output logic                           pend_valid_o,
  output logic [$clog2(NUM_VEC)-1:0]     pend_vec_o,
  output logic [$clog2(NUM_VEC)-1:0]     ppr_o,
  output logic [WORD_W-1:0]              irr_word_o,
  output logic [WORD_W-1:0]              isr_word_o
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam logic [NUM_VEC-1:0] SCAN_MASK = {NUM_VEC{1'b1}} << RSVD;

  logic [NUM_VEC-1:0] irr_q, isr_q, irr_d, isr_d;
  logic [VEC_W-1:0]   tpr_q;

  logic               irr_found, isr_found;
  logic [VEC_W-1:0]   irr_top, isr_idx, isr_top;
  logic [NUM_VEC-1:0] set_bit, acc_bit, eoi_bit;
  logic               take;

  vpt_msb_find #(.N(NUM_VEC), .IW(VEC_W)) u_irr_find (
    .vec_i(irr_q & SCAN_MASK), .found_o(irr_found), .idx_o(irr_top)
  );
  vpt_msb_find #(.N(NUM_VEC), .IW(VEC_W)) u_isr_find (
    .vec_i(isr_q & SCAN_MASK), .found_o(isr_found), .idx_o(isr_idx)
  );

  // empty in-service set counts as vector 0
  assign isr_top = isr_found ? isr_idx : '0;

  vpt_ppr_calc #(.VEC_W(VEC_W)) u_ppr (
    .tpr_i(tpr_q), .isr_top_i(isr_top), .ppr_o(ppr_o)
  );

  assign pend_valid_o = irr_found &&
                        (irr_top[VEC_W-1 -: CLS_W] > ppr_o[VEC_W-1 -: CLS_W]);
  assign pend_vec_o   = pend_valid_o ? irr_top : '0;
  assign take         = ack_i && pend_valid_o;

  assign set_bit = set_valid_i ? (NUM_VEC'(1) << set_vec_i) : '0;
  assign acc_bit = take ? (NUM_VEC'(1) << irr_top) : '0;
  assign eoi_bit = (eoi_i && isr_found) ? (NUM_VEC'(1) << isr_idx) : '0;

  // a new request beats an accept of the same vector
  assign irr_d = (irr_q & ~acc_bit) | set_bit;
  assign isr_d = (isr_q & ~eoi_bit) | acc_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tpr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      if (tpr_we_i) tpr_q <= tpr_wdata_i[VEC_W-1:0];
    end
  end

  assign irr_word_o = irr_q[rd_sel_i*WORD_W +: WORD_W];
  assign isr_word_o = isr_q[rd_sel_i*WORD_W +: WORD_W];
endmodule

module vec_prio_tracker_chk #(
  parameter int NUM_VEC = 256,
  parameter int TPR_W   = 32,
  parameter int RSVD    = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       set_valid_i,
  input logic [$clog2(NUM_VEC)-1:0] set_vec_i,
  input logic                       ack_i,
  input logic                       eoi_i,
  input logic                       tpr_we_i,
  input logic [TPR_W-1:0]           tpr_wdata_i,
  input logic                       pend_valid_o,
  input logic [$clog2(NUM_VEC)-1:0] pend_vec_o,
  input logic [$clog2(NUM_VEC)-1:0] ppr_o,
  input logic [NUM_VEC-1:0]         irr_q,
  input logic [NUM_VEC-1:0]         isr_q,
  input logic [$clog2(NUM_VEC)-1:0] tpr_q
);
  localparam int VEC_W = $clog2(NUM_VEC);

  // R4
  offer_beats_ppr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> (pend_vec_o[VEC_W-1 -: 4] > ppr_o[VEC_W-1 -: 4]));

  // R4
  offer_not_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> (int'(pend_vec_o) >= RSVD));

  // R2
  ppr_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppr_o == tpr_q) || (ppr_o[3:0] == 4'h0 && ppr_o[VEC_W-1 -: 4] > tpr_q[VEC_W-1 -: 4]));

  // R3
  idle_ppr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr_q == '0) |-> (ppr_o == tpr_q));

  // R5
  accept_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_valid_o) |=> isr_q[$past(pend_vec_o)]);

  // R5
  accept_clears_irr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_valid_o && !(set_valid_i && set_vec_i == pend_vec_o))
      |=> !irr_q[$past(pend_vec_o)]);

  // R9
  accept_set_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend_valid_o && set_valid_i && set_vec_i == pend_vec_o)
      |=> irr_q[$past(pend_vec_o)]);

  // R6
  eoi_pops_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(ack_i && pend_valid_o) && (isr_q != '0))
      |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

  // R7
  tpr_low_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_we_i |=> (tpr_q == $past(tpr_wdata_i[VEC_W-1:0])));
endmodule

bind vec_prio_tracker vec_prio_tracker_chk #(
  .NUM_VEC(NUM_VEC), .TPR_W(TPR_W), .RSVD(RSVD)
) u_chk (.*);

// File: tb/vec_prio_tracker_bench.sv
module vec_prio_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_valid_i = 1'b0;
  logic [7:0]  set_vec_i = '0;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic        tpr_we_i = 1'b0;
  logic [31:0] tpr_wdata_i = '0;
  logic [2:0]  rd_sel_i = '0;
  logic        pend_valid_o;
  logic [7:0]  pend_vec_o, ppr_o;
  logic [31:0] irr_word_o, isr_word_o;

  always #2 clk = ~clk;  // 250 MHz

  vec_prio_tracker u_vec_prio_tracker (
    .clk_i(clk), .rst_ni(rst_ni),
    .set_valid_i(set_valid_i), .set_vec_i(set_vec_i),
    .ack_i(ack_i), .eoi_i(eoi_i),
    .tpr_we_i(tpr_we_i), .tpr_wdata_i(tpr_wdata_i),
    .rd_sel_i(rd_sel_i),
    .pend_valid_o(pend_valid_o), .pend_vec_o(pend_vec_o), .ppr_o(ppr_o),
    .irr_word_o(irr_word_o), .isr_word_o(isr_word_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference
  logic [255:0] m_irr = '0, m_isr = '0;
  int           m_tpr = 0;

  function automatic int m_isr_top();
    for (int v = 255; v >= 32; v--) if (m_isr[v]) return v;
    return 0;
  endfunction

  function automatic int m_ppr();
    int t = m_isr_top();
    if ((m_tpr / 16) >= (t / 16)) return m_tpr;
    return (t / 16) * 16;
  endfunction

  function automatic int m_pend();
    for (int v = 255; v >= 32; v--)
      if (m_irr[v]) return ((v / 16) > (m_ppr() / 16)) ? v : -1;
    return -1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int p = m_pend();
    chk(req, "pend_valid", int'(pend_valid_o), (p >= 0) ? 1 : 0);
    if (p >= 0) chk(req, "pend_vec", int'(pend_vec_o), p);
    chk(req, "ppr", int'(ppr_o), m_ppr());
    chk(req, "irr_word", int'(irr_word_o), int'(m_irr[rd_sel_i*32 +: 32]));
    chk(req, "isr_word", int'(isr_word_o), int'(m_isr[rd_sel_i*32 +: 32]));
  endtask

  // one cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic step(input string req, input bit sv, input int vec, input bit ack,
                      input bit eoi, input bit tw, input logic [31:0] td, input int sel);
    logic [255:0] n_irr, n_isr;
    int p, t;
    set_valid_i = sv; set_vec_i = 8'(vec); ack_i = ack; eoi_i = eoi;
    tpr_we_i = tw; tpr_wdata_i = td; rd_sel_i = 3'(sel);
    p = m_pend(); t = m_isr_top();
    n_irr = m_irr; n_isr = m_isr;
    if (eoi && t != 0) n_isr[t] = 1'b0;
    if (ack && p >= 0) begin n_irr[p] = 1'b0; n_isr[p] = 1'b1; end
    if (sv) n_irr[vec] = 1'b1;
    @(posedge clk);
    m_irr = n_irr; m_isr = n_isr;
    if (tw) m_tpr = int'(td[7:0]);
    @(negedge clk);
    set_valid_i = 0; ack_i = 0; eoi_i = 0; tpr_we_i = 0;
    compare(req);
  endtask

  task automatic idle(input string req, input int sel);
    step(req, 0, 0, 0, 0, 0, 32'h0, sel);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    idle("R1", 0);

    // R4 offer and reserved floor, R10 word placement
    step("R4", 1, 8'h45, 0, 0, 0, 0, 2);
    chk("R4", "offer 45", int'(pend_vec_o), 8'h45);
    step("R4", 1, 8'h10, 0, 0, 0, 0, 0);
    chk("R10", "word0 bit16", int'(irr_word_o[16]), 1);
    idle("R10", 2);
    chk("R10", "word2 bit5", int'(irr_word_o[5]), 1);
    // R8 repeated request
    step("R8", 1, 8'h45, 0, 0, 0, 0, 2);
    chk("R8", "irr word2", int'(irr_word_o), 32'h20);
    // R5 accept, R2 ppr follows
    step("R5", 0, 0, 1, 0, 0, 0, 2);
    chk("R5", "isr word2", int'(isr_word_o), 32'h20);
    chk("R2", "ppr after accept", int'(ppr_o), 8'h40);
    chk("R4", "nothing offered", int'(pend_valid_o), 0);
    // R4 same class held, higher class offered
    step("R4", 1, 8'h47, 0, 0, 0, 0, 2);
    chk("R4", "same class held", int'(pend_valid_o), 0);
    step("R4", 1, 8'h80, 0, 0, 0, 0, 4);
    chk("R4", "higher class offered", int'(pend_vec_o), 8'h80);
    step("R5", 0, 0, 1, 0, 0, 0, 4);
    chk("R2", "ppr nested", int'(ppr_o), 8'h80);
    // R6 EOI unwinds
    step("R6", 0, 0, 0, 1, 0, 0, 4);
    chk("R6", "ppr after eoi", int'(ppr_o), 8'h40);
    // R7 TPR low byte, R2 TPR arm
    step("R7", 0, 0, 0, 0, 1, 32'h1234_5567, 2);
    chk("R7", "ppr from tpr", int'(ppr_o), 8'h67);
    step("R2", 0, 0, 0, 0, 1, 32'hFFFF_FF35, 2);
    chk("R2", "isr arm", int'(ppr_o), 8'h40);
    step("R6", 0, 0, 0, 1, 0, 0, 2);
    chk("R3", "empty isr ppr=tpr", int'(ppr_o), 8'h35);
    chk("R4", "47 offered", int'(pend_vec_o), 8'h47);
    // R9 set and accept of same vector
    step("R9", 1, 8'h47, 1, 0, 0, 0, 2);
    chk("R9", "still pending", int'(irr_word_o[7]), 1);
    chk("R9", "in service", int'(isr_word_o[7]), 1);
    step("R6", 0, 0, 0, 1, 0, 0, 2);
    step("R6", 0, 0, 0, 1, 0, 0, 2);
    step("R6", 0, 0, 0, 1, 0, 0, 2);
    chk("R6", "empty eoi no effect", int'(isr_word_o), 0);
    step("R4", 0, 0, 0, 0, 1, 32'hF0, 2);
    step("R5", 0, 0, 1, 0, 0, 0, 2);
    chk("R5", "ack ignored", int'(isr_word_o), 0);
    step("R4", 0, 0, 0, 0, 1, 32'h00, 2);

    // R11 random traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom;
      step("R11", (r % 3) == 0, $urandom_range(255, 0), (r % 5) == 1,
           (r % 7) == 2, (r % 23) == 3, $urandom, n % 8);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule